// File: doc/BRIEF.md
# Word-Systolic Radix-2 Montgomery Multiplier

This block computes the Montgomery product of two operands for an odd modulus of N bits: the result is congruent to X·Y·2^-N modulo M and lies below 2M. The running sum is split into E = ceil((N+1)/W) words of W bits. A linear array of E cells, one per word, updates all words together, and each cell works on a different multiplier bit in the same cycle. The multiplier X moves through a one-bit delay line beside the array, one position per cycle, and so do the reduction bits that the lowest cell produces.

Each cell except the top one keeps two candidate values for its carry out and its word's top bit. One candidate assumes that the low bit the next cell up is still producing is 0, the other that it is 1. The cell picks the right pair one cycle later, when that bit is in a register. Neighbouring cells therefore run only one cycle apart. X, Y and M load in parallel on an accepted start pulse. After N real rounds and one round with a zero feed, `done` rises and the result holds still on `zOut` for a parallel read. Reducing the result below M and converting values into and out of the Montgomery domain are left to the surrounding logic. W must be at least 4.

Top module: `mont_systolic_mul`

## Requirements
- R1: After reset, `done` is 0 and `zOut` is all zeros.
- R2: For odd M with bit N-1 set and X, Y < M, `zOut` equals the value S reached by the bit-serial recurrence S0 = 0, S(i+1) = (S(i) + x_i·Y + q_i·M)/2 for i = 0..N-1, where q_i makes the numerator even. That value is congruent to X·Y·2^-N mod M.
- R3: For such operands the result is below 2M. Every inter-cell carry stays at 2 or less, and the top cell's sum always fits in W+1 bits.
- R4: `done` rises exactly N+E clock edges after the edge that samples the accepted `start`, where E = ceil((N+1)/W).
- R5: Once `done` is high, it stays high and `zOut` stays unchanged until the next accepted start, whatever the operand inputs do.
- R6: A `start` pulse that arrives while a multiplication runs is ignored. The result and the completion cycle of the running multiplication are unchanged.
- R7: An accepted start clears all state from the previous multiplication, so back-to-back multiplications are independent.
- R8: X = 0 gives a zero result, because the zero multiplier bits cancel every Y and M addition.
- R9: The operands are captured only in the cycle start is accepted. Changing `xIn`, `yIn` or `mIn` during a multiplication has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| xIn | input | N | Multiplier X, captured on an accepted start |
| yIn | input | N | Multiplicand Y, captured on an accepted start |
| mIn | input | N | Odd modulus M, captured on an accepted start |
| done | output | 1 | Result valid and frozen |
| zOut | output | E·W | Result words, lowest word in the low bits |

## Verification
The bench targets the places where a word array can go wrong while a plain multiplier would not. It uses moduli with every bit set and moduli with only the top and bottom bits set. These drive the carry to its largest value, so a cell that kept a one-bit carry or picked the wrong candidate would produce a result that is off by a multiple of a word boundary. It checks that the extra zero-feed round and the per-cell freeze give exact words, and checks the completion cycle, because an off-by-one in the reduction-bit delay line or in the freeze order would leave a word one round stale. It also checks that a late start pulse, operand changes during a run and a back-to-back restart leave no trace: any of these would either restart the array part-way through or mix leftover carries into the next product.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Strobes from the sequencer to the word array.
  typedef struct packed {
    logic clear;     // load operands, zero all array state
    logic advance;   // one round step for every active cell
    logic zeroFeed;  // multiplier bits are exhausted: force reduction bit to 0
    logic tailGo;    // launch the freeze wave at the lowest cell
  } mm_ctl_t;
endpackage

// File: rtl/mm_pe.sv
// Word cell with dual-candidate carry and top bit.
module mm_pe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         run,
  input  logic         resolve,
  input  logic         xBit,
  input  logic         qBit,
  input  logic [W-1:0] yWord,
  input  logic [W-1:0] mWord,
  input  logic [1:0]   cin,
  input  logic         nbrLsb,
  output logic [1:0]   cout,
  output logic [W-1:0] word
);
  logic [W-2:0] lowR;
  logic         msb0R, msb1R;
  logic [1:0]   car0R, car1R;
  logic         sealed;
  logic         msbSel;
  logic [1:0]   carSel;
  logic [W+1:0] base, alt;

  always_comb begin
    msbSel = nbrLsb ? msb1R : msb0R;
    carSel = nbrLsb ? car1R : car0R;
    base   = (W+2)'({msbSel, lowR[W-2:1]}) + (W+2)'(cin)
           + (xBit ? (W+2)'(yWord) : '0) + (qBit ? (W+2)'(mWord) : '0);
    alt    = base + ((W+2)'(1) << (W-1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowR <= '0; msb0R <= 1'b0; msb1R <= 1'b0;
      car0R <= '0; car1R <= '0; sealed <= 1'b0;
    end else if (clear) begin
      lowR <= '0; msb0R <= 1'b0; msb1R <= 1'b0;
      car0R <= '0; car1R <= '0; sealed <= 1'b0;
    end else if (resolve) begin
      msb0R  <= msbSel;
      msb1R  <= msbSel;
      car0R  <= carSel;
      car1R  <= carSel;
      sealed <= 1'b1;
    end else if (run && !sealed) begin
      lowR  <= base[W-2:0];
      msb0R <= base[W-1];
      car0R <= base[W+1:W];
      msb1R <= alt[W-1];
      car1R <= alt[W+1:W];
    end
  end

  assign word = {msbSel, lowR};
  assign cout = carSel;

  // R3: both carry candidates stay within 0..2
  a_r3_carry_le2: assert property (@(posedge clk) disable iff (!rstN)
    (car0R <= 2'd2) && (car1R <= 2'd2));
endmodule

// File: rtl/mm_pe_tail.sv
// Top word cell: its shifted-in bit is its own previous carry.
module mm_pe_tail #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         run,
  input  logic         xBit,
  input  logic         qBit,
  input  logic [W-1:0] yWord,
  input  logic [W-1:0] mWord,
  input  logic [1:0]   cin,
  output logic [W-1:0] word
);
  logic [W-1:0] wordR;
  logic         carR;
  logic [W+1:0] sumWide;

  always_comb
    sumWide = (W+2)'({carR, wordR[W-1:1]}) + (W+2)'(cin)
            + (xBit ? (W+2)'(yWord) : '0) + (qBit ? (W+2)'(mWord) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordR <= '0; carR <= 1'b0;
    end else if (clear) begin
      wordR <= '0; carR <= 1'b0;
    end else if (run) begin
      wordR <= sumWide[W-1:0];
      carR  <= sumWide[W];
    end
  end

  assign word = wordR;

  // R3: the top word never overflows W+1 bits
  a_r3_tail_fits: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (sumWide[W+1] == 1'b0));
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mm_ctl_t ctl,
  output logic    done
);
  localparam int E    = (N + W) / W;
  localparam int LAST = N + E - 1;
  localparam int CW   = $clog2(N + E + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; cnt <= '0; done <= 1'b0;
    end else if (start && !busy) begin
      busy <= 1'b1; cnt <= '0; done <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(LAST)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.clear    = start && !busy;
    ctl.advance  = busy;
    ctl.zeroFeed = busy && (cnt >= CW'(N));
    ctl.tailGo   = busy && (cnt == CW'(N));
  end

  // R4: done rises only at the end of the final step
  a_r4_done_at_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && ($past(cnt) == CW'(LAST))));
  // R6: a start during a run does not disturb the step count
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (cnt != CW'(LAST))) |=> (busy && (cnt == CW'($past(cnt) + 1'b1))));
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mm_ctl_t                ctl,
  input  logic [N-1:0]           xIn,
  input  logic [N-1:0]           yIn,
  input  logic [N-1:0]           mIn,
  output logic [((N+W)/W)*W-1:0] zOut
);
  localparam int E  = (N + W) / W;
  localparam int EW = E * W;

  logic [N-1:0]  xSr;
  logic [EW-1:0] yReg, mReg;
  logic [E-1:1]  xDly, qDly;
  logic [E-2:0]  tok;
  logic          xCur, qNow;
  logic [W-1:0]  wordArr [E];
  logic [1:0]    carArr  [1:E-1];

  assign xCur = xSr[0];
  assign qNow = !ctl.zeroFeed && ((xCur & yReg[0]) ^ wordArr[0][1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xSr <= '0; yReg <= '0; mReg <= '0;
      xDly <= '0; qDly <= '0; tok <= '0;
    end else if (ctl.clear) begin
      xSr  <= xIn;
      yReg <= EW'(yIn);
      mReg <= EW'(mIn);
      xDly <= '0; qDly <= '0; tok <= '0;
    end else if (ctl.advance) begin
      xSr     <= xSr >> 1;
      xDly[1] <= xCur;
      qDly[1] <= qNow;
      for (int k = 2; k < E; k++) begin
        xDly[k] <= xDly[k-1];
        qDly[k] <= qDly[k-1];
      end
      tok[0] <= ctl.tailGo;
      for (int k = 1; k < E - 1; k++) tok[k] <= tok[k-1];
    end
  end

  for (genvar j = 0; j < E - 1; j++) begin : g_col
    logic       xb, qb;
    logic [1:0] cinJ;
    if (j == 0) begin : g_head
      assign xb = xCur;
      assign qb = qNow;
      assign cinJ = 2'b00;
    end else begin : g_mid
      assign xb = xDly[j];
      assign qb = qDly[j];
      assign cinJ = carArr[j];
    end
    mm_pe #(.W(W)) u_pe (
      .clk(clk), .rstN(rstN), .clear(ctl.clear), .run(ctl.advance),
      .resolve(tok[j] && ctl.advance),
      .xBit(xb), .qBit(qb),
      .yWord(yReg[j*W +: W]), .mWord(mReg[j*W +: W]),
      .cin(cinJ), .nbrLsb(wordArr[j+1][0]),
      .cout(carArr[j+1]), .word(wordArr[j])
    );
  end

  mm_pe_tail #(.W(W)) u_tail (
    .clk(clk), .rstN(rstN), .clear(ctl.clear), .run(ctl.advance),
    .xBit(xDly[E-1]), .qBit(qDly[E-1]),
    .yWord(yReg[(E-1)*W +: W]), .mWord(mReg[(E-1)*W +: W]),
    .cin(carArr[E-1]), .word(wordArr[E-1])
  );

  always_comb
    for (int j = 0; j < E; j++) zOut[j*W +: W] = wordArr[j];

  // R5: with no step and no load, the result words do not move
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clear) |=> $stable(zOut));
endmodule

// File: rtl/mont_systolic_mul.sv
module mont_systolic_mul
  import mm_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [N-1:0]           xIn,
  input  logic [N-1:0]           yIn,
  input  logic [N-1:0]           mIn,
  output logic                   done,
  output logic [((N+W)/W)*W-1:0] zOut
);
  mm_ctl_t ctlStrobes;

  mm_ctrl #(.N(N), .W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctlStrobes), .done(done)
  );

  mm_datapath #(.N(N), .W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobes),
    .xIn(xIn), .yIn(yIn), .mIn(mIn), .zOut(zOut)
  );
endmodule

// File: tb/tb_mont_systolic_mul.sv
`timescale 1ns/1ps
module tb_mont_systolic_mul;
  localparam int N  = 64;
  localparam int W  = 16;
  localparam int E  = (N + W) / W;
  localparam int EW = E * W;
  localparam int WD = 3 * N + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  xIn = '0, yIn = '0, mIn = '0;
  logic          done;
  logic [EW-1:0] zOut;
  int            testCnt = 0;
  int            failCnt = 0;

  always #2 clk = ~clk;

  mont_systolic_mul #(.N(N), .W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .xIn(xIn), .yIn(yIn), .mIn(mIn), .done(done), .zOut(zOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WD-1:0] act, input logic [WD-1:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N+1:0] refMont(input logic [N-1:0] xa, ya, ma);
    logic [N+1:0] s = '0;
    logic [N+1:0] t;
    for (int i = 0; i < N; i++) begin
      t = s + (xa[i] ? (N+2)'(ya) : '0);
      if (t[0]) t = t + (N+2)'(ma);
      s = t >> 1;
    end
    return s;
  endfunction

  function automatic logic [N-1:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  // Runs one multiplication; disturb pulses start and scrambles inputs mid-run.
  task automatic runMul(input logic [N-1:0] xa, ya, ma, input bit disturb,
                        input string tag, output logic [EW-1:0] zr);
    int cyc;
    logic [WD-1:0] lhs, rhs, zw, mw;
    logic [N+1:0] expS;
    @(negedge clk);
    xIn = xa; yIn = ya; mIn = ma; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 7) begin
        xIn = ~xa; yIn = ~ya; mIn = ~ma;   // R9: late operand changes
        if (disturb) start = 1'b1;          // R6: start while busy
      end else begin
        start = 1'b0;
      end
    end
    zr   = zOut;
    expS = refMont(xa, ya, ma);
    check(cyc == N + E, "R4", {tag, " latency"}, WD'(cyc), WD'(N + E));
    check(zr == EW'(expS), "R2", {tag, " exact value"}, WD'(zr), WD'(expS));
    zw  = WD'(zr);
    mw  = WD'(ma);
    lhs = (zw << N) % mw;
    rhs = (WD'(xa) * WD'(ya)) % mw;
    check(lhs == rhs, "R2", {tag, " congruence"}, lhs, rhs);
    check(zw < (mw << 1), "R3", {tag, " below 2M"}, zw, mw << 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", WD'(done), '0);
    check(zOut == '0, "R1", "result after reset", WD'(zOut), '0);
  endtask

  task automatic testEdgeOperands();
    logic [EW-1:0] z;
    logic [N-1:0] mMax = '1;
    logic [N-1:0] mMin = (N'(1) << (N-1)) | N'(1);
    runMul('0, mMax - 2, mMax, 1'b0, "X zero", z);
    check(z == '0, "R8", "zero multiplier", WD'(z), '0);
    runMul(N'(1), N'(1), mMin, 1'b0, "unit operands", z);
    runMul(mMax - 1, mMax - 1, mMax, 1'b0, "max modulus", z);
    runMul(mMin - 1, mMin - 1, mMin, 1'b0, "sparse modulus", z);
    runMul(mMax - 1, N'(1), mMax, 1'b0, "Y one", z);
  endtask

  task automatic testRandom();
    logic [EW-1:0] z;
    for (int k = 0; k < 10; k++) begin
      logic [N-1:0] m = rand64() | (N'(1) << (N-1)) | N'(1);
      runMul(rand64() % m, rand64() % m, m, 1'b0, "random", z);
    end
  endtask

  task automatic testHold();
    logic [EW-1:0] z, z0;
    logic [N-1:0] m = rand64() | (N'(1) << (N-1)) | N'(1);
    runMul(rand64() % m, rand64() % m, m, 1'b0, "hold", z);
    xIn = rand64(); yIn = rand64(); mIn = rand64();
    z0 = zOut;
    repeat (25) @(negedge clk);
    check(done == 1'b1, "R5", "done held", WD'(done), WD'(1));
    check(zOut == z0, "R5", "result held", WD'(zOut), WD'(z0));
  endtask

  task automatic testStartIgnored();
    logic [EW-1:0] z;
    logic [N-1:0] m = rand64() | (N'(1) << (N-1)) | N'(1);
    runMul(rand64() % m, rand64() % m, m, 1'b1, "R6 start while busy", z);
  endtask

  task automatic testBackToBack();
    logic [EW-1:0] z;
    logic [N-1:0] m = rand64() | (N'(1) << (N-1)) | N'(1);
    runMul(m - 1, m - 1, m, 1'b0, "R7 first", z);
    runMul('0, m - 1, m, 1'b0, "R7 second", z);
    check(z == '0, "R7", "no leftover state", WD'(z), '0);
    runMul(m - 3, m - 5, m, 1'b0, "R7 third", z);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEdgeOperands();
    testRandom();
    testHold();
    testStartIgnored();
    testBackToBack();
    summary();
    $finish;
  end
endmodule